// File: doc/BRIEF.md
# Reset Cause Recorder

This block records why the chip was last reset. It sits in an always-on domain that only a power-on reset clears. Four event inputs report the other reset sources: the external pin, a software request, the independent watchdog and the window watchdog. Each event sets its own sticky flag. A power-on reset clears the other flags and leaves only its own flag set. Software reads the flags through a 32-bit control/status register. A single write of the remove-flags bit clears all of them.

A fixed-priority encoder turns the flags into one 8-bit cause code. On a store request the block merges a nonzero code into the low byte of a retained 16-bit backup word and leaves the upper byte as it was. Firmware can also write the whole backup word. Both kinds of backup write are gated by a backup-domain write enable. An optional escalation counter counts watchdog-caused resets and raises an alarm once a programmable limit is reached.

Top module: `reset_cause_recorder`

## Requirements
- R1: While `rst` (power-on) is high, the flags become power-on only (`csr_rdata_o` = 0x2 and cause code 5). The backup word and the escalation count become 0.
- R2: Event bits map to flags as follows: `rst_evt_i[0]` pin sets flag bit 0, `[1]` software sets bit 2, `[2]` independent watchdog sets bit 3, `[3]` window watchdog sets bit 4. An event sets only its own flag. All other flags keep their values.
- R3: `csr_rdata_o` shows the flags in bits 4:0, one cycle after the flags update. Every other bit reads 0, including the remove-flags bit 24.
- R4: A CSR write with bit 24 = 1 clears all five flags. If an event arrives in the same cycle, its flag is still set. A CSR write with bit 24 = 0 changes nothing.
- R5: The cause code takes the highest-priority set flag: independent watchdog 1, window watchdog 2, software 3, pin 4, power-on 5. With no flag set the code is 0.
- R6: A store with the write enable set and a nonzero code writes the code into backup bits 7:0 and leaves bits 15:8 unchanged. The code used is the one from the flags before that clock edge.
- R7: A store while the code is 0 leaves the backup word unchanged.
- R8: With the backup write enable low, neither a store nor a software backup write changes the backup word.
- R9: A software backup write with the enable set loads all 16 bits. If an effective store happens in the same cycle, the code replaces bits 7:0.
- R10: The backup word is unaffected by events, by flag removal and by CSR writes. Only power-on clears it.
- R11: Each cycle with a watchdog event (independent or window) adds one to the escalation count, which saturates at its maximum. `esc_alarm_o` is high once the count reaches `ESC_LIMIT`. Flag removal does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_evt_i | input | 4 | Non-power-on reset events: pin, software, independent watchdog, window watchdog |
| csr_wr_i | input | 1 | Control/status register write strobe |
| csr_wdata_i | input | CSR_W | CSR write data; bit RMV_BIT removes the flags |
| csr_rdata_o | output | CSR_W | CSR read value with the flags in the low bits |
| bkp_wr_en_i | input | 1 | Backup-domain write enable |
| bkp_wr_i | input | 1 | Software write of the backup word |
| bkp_wdata_i | input | BKP_W | Backup word write data |
| store_i | input | 1 | Merge the current cause code into the backup low byte |
| bkp_word_o | output | BKP_W | Retained backup word |
| cause_code_o | output | CODE_W | Registered priority cause code |
| esc_cnt_o | output | ESC_CNT_W | Saturating count of watchdog resets |
| esc_alarm_o | output | 1 | Escalation count has reached ESC_LIMIT |

## Verification
The bench builds the block with a 3-bit escalation counter and a limit of 3. With these values a handful of watchdog events is enough to cross the alarm threshold and then hold the count at its saturation value of 7. The default 32-bit CSR and 16-bit backup word are kept, so the remove bit at position 24 and the preserved upper byte are exercised as they would be in use. Random mixes of simultaneous events, removals, stores and backup writes reach the same-edge orderings that directed cases alone would miss.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int FLAG_N    = 5;
  localparam int EVT_N     = 4;
  // flag bit positions as read through the CSR
  localparam int F_PIN     = 0;
  localparam int F_POR     = 1;
  localparam int F_SW      = 2;
  localparam int F_IWD     = 3;
  localparam int F_WWD     = 4;
  // event input positions
  localparam int E_PIN     = 0;
  localparam int E_SW      = 1;
  localparam int E_IWD     = 2;
  localparam int E_WWD     = 3;
  // cause codes
  localparam int C_NONE    = 0;
  localparam int C_IWD     = 1;
  localparam int C_WWD     = 2;
  localparam int C_SW      = 3;
  localparam int C_PIN     = 4;
  localparam int C_POR     = 5;
endpackage

// File: rtl/rcr_flags.sv
module rcr_flags
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic              clr_i,
  output logic [FLAG_N-1:0] flags_o
);
  logic [FLAG_N-1:0] set_v;

  always_comb begin
    set_v        = '0;
    set_v[F_PIN] = evt_i[E_PIN];
    set_v[F_SW]  = evt_i[E_SW];
    set_v[F_IWD] = evt_i[E_IWD];
    set_v[F_WWD] = evt_i[E_WWD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o        <= '0;
      flags_o[F_POR] <= 1'b1;
    end else begin
      flags_o <= (clr_i ? '0 : flags_o) | set_v;
    end
  end

  // R2
  sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && evt_i == '0) |=> $stable(flags_o));
  // R4
  remove_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_i == '0) |=> (flags_o == '0));
endmodule

// File: rtl/rcr_prio_enc.sv
module rcr_prio_enc
  import rcr_pkg::*;
#(
  parameter int CODE_W = 8
)(
  input  logic [FLAG_N-1:0] flags_i,
  output logic [CODE_W-1:0] code_o
);
  // lowest priority first, later assignments win
  always_comb begin
    code_o = CODE_W'(C_NONE);
    if (flags_i[F_POR]) code_o = CODE_W'(C_POR);
    if (flags_i[F_PIN]) code_o = CODE_W'(C_PIN);
    if (flags_i[F_SW])  code_o = CODE_W'(C_SW);
    if (flags_i[F_WWD]) code_o = CODE_W'(C_WWD);
    if (flags_i[F_IWD]) code_o = CODE_W'(C_IWD);
  end
endmodule

// File: rtl/rcr_backup.sv
module rcr_backup #(
  parameter int BKP_W  = 16,
  parameter int CODE_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              we_en_i,
  input  logic              sw_wr_i,
  input  logic [BKP_W-1:0]  sw_wdata_i,
  input  logic              store_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [BKP_W-1:0]  word_o
);
  logic [BKP_W-1:0] nxt;

  always_comb begin
    nxt = word_o;
    if (we_en_i) begin
      if (sw_wr_i) nxt = sw_wdata_i;
      if (store_i && code_i != '0) nxt[CODE_W-1:0] = code_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= nxt;
  end

  // R8
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !we_en_i |=> $stable(word_o));
  // R6
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_wr_i |=> $stable(word_o[BKP_W-1:CODE_W]));
  // R7
  zero_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr_i && code_i == '0) |=> $stable(word_o));
endmodule

// File: rtl/rcr_escalate.sv
module rcr_escalate #(
  parameter int CNT_W = 4,
  parameter int LIMIT = 3
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      alarm_o <= 1'b0;
    end else begin
      if (wd_evt_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      alarm_o <= (cnt_o >= LIM);
    end
  end

  // R11
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_o >= $past(cnt_o)));
  // R11
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/reset_cause_recorder.sv
module reset_cause_recorder
  import rcr_pkg::*;
#(
  parameter int CSR_W     = 32,
  parameter int RMV_BIT   = 24,
  parameter int BKP_W     = 16,
  parameter int CODE_W    = 8,
  parameter bit ESC_EN    = 1'b1,
  parameter int ESC_CNT_W = 4,
  parameter int ESC_LIMIT = 3
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           rst_evt_i,
  input  logic                 csr_wr_i,
  input  logic [CSR_W-1:0]     csr_wdata_i,
  output logic [CSR_W-1:0]     csr_rdata_o,
  input  logic                 bkp_wr_en_i,
  input  logic                 bkp_wr_i,
  input  logic [BKP_W-1:0]     bkp_wdata_i,
  input  logic                 store_i,
  output logic [BKP_W-1:0]     bkp_word_o,
  output logic [CODE_W-1:0]    cause_code_o,
  output logic [ESC_CNT_W-1:0] esc_cnt_o,
  output logic                 esc_alarm_o
);
  localparam int PAD_W = CSR_W - FLAG_N;

  logic [FLAG_N-1:0] flags;
  logic [CODE_W-1:0] code_comb;
  logic              remove;
  logic              unused_wdata;

  assign remove       = csr_wr_i && csr_wdata_i[RMV_BIT];
  assign unused_wdata = ^csr_wdata_i;

  rcr_flags u_flags (
    .clk(clk), .rst(rst), .evt_i(rst_evt_i), .clr_i(remove), .flags_o(flags)
  );

  rcr_prio_enc #(.CODE_W(CODE_W)) u_enc (.flags_i(flags), .code_o(code_comb));

  rcr_backup #(.BKP_W(BKP_W), .CODE_W(CODE_W)) u_bkp (
    .clk(clk), .rst(rst), .we_en_i(bkp_wr_en_i), .sw_wr_i(bkp_wr_i),
    .sw_wdata_i(bkp_wdata_i), .store_i(store_i), .code_i(code_comb),
    .word_o(bkp_word_o)
  );

  generate
    if (ESC_EN) begin : g_esc
      rcr_escalate #(.CNT_W(ESC_CNT_W), .LIMIT(ESC_LIMIT)) u_esc (
        .clk(clk), .rst(rst),
        .wd_evt_i(rst_evt_i[E_IWD] | rst_evt_i[E_WWD]),
        .cnt_o(esc_cnt_o), .alarm_o(esc_alarm_o)
      );
    end else begin : g_no_esc
      assign esc_cnt_o   = '0;
      assign esc_alarm_o = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata_o        <= '0;
      csr_rdata_o[F_POR] <= 1'b1;
      cause_code_o       <= CODE_W'(C_POR);
    end else begin
      csr_rdata_o  <= {{PAD_W{1'b0}}, flags};
      cause_code_o <= code_comb;
    end
  end

  // R5
  code_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (flags != '0) |=> (cause_code_o != '0));
  // R5
  code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> (cause_code_o == '0));
  // R3
  rdata_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (csr_rdata_o[FLAG_N-1:0] == $past(flags)));
endmodule

// File: tb/reset_cause_recorder_bench.sv
module reset_cause_recorder_bench;
  localparam int CW = 3;
  localparam int LIM = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  evt;
  logic        cwr;
  logic [31:0] cwd;
  logic [31:0] rdata;
  logic        we, bwr, st;
  logic [15:0] bwd, bkp;
  logic [7:0]  code;
  logic [CW-1:0] cnt;
  logic        alarm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [4:0]  m_flags;
  logic [15:0] m_bkp;
  int          m_cnt;

  always #10 clk = ~clk;

  reset_cause_recorder #(.ESC_CNT_W(CW), .ESC_LIMIT(LIM)) u_reset_cause_recorder (
    .clk(clk), .rst(rst), .rst_evt_i(evt), .csr_wr_i(cwr), .csr_wdata_i(cwd),
    .csr_rdata_o(rdata), .bkp_wr_en_i(we), .bkp_wr_i(bwr), .bkp_wdata_i(bwd),
    .store_i(st), .bkp_word_o(bkp), .cause_code_o(code), .esc_cnt_o(cnt),
    .esc_alarm_o(alarm)
  );

  function automatic logic [7:0] exp_code(input logic [4:0] f);
    if (f[3]) return 8'd1;
    if (f[4]) return 8'd2;
    if (f[2]) return 8'd3;
    if (f[0]) return 8'd4;
    if (f[1]) return 8'd5;
    return 8'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt = '0; cwr = 0; cwd = '0; we = 0; bwr = 0; bwd = '0; st = 0;
  endtask

  task automatic check_all(input string req);
    chk({req, " csr"},   rdata, {27'b0, m_flags});
    chk({req, " code"},  {24'b0, code}, {24'b0, exp_code(m_flags)});
    chk({req, " bkp"},   {16'b0, bkp}, {16'b0, m_bkp});
    chk({req, " cnt"},   {29'b0, cnt}, 32'(m_cnt));
    chk({req, " alarm"}, {31'b0, alarm}, {31'b0, (m_cnt >= LIM)});
  endtask

  task automatic do_por(input string req);
    @(negedge clk); rst = 1; idle();
    @(negedge clk); @(negedge clk); rst = 0;
    m_flags = 5'b00010; m_bkp = '0; m_cnt = 0;
    @(negedge clk);
    check_all(req);
  endtask

  task automatic op(input logic [3:0] e, input logic cw, input logic [31:0] cd,
                    input logic w, input logic bw, input logic [15:0] bd,
                    input logic s, input string req);
    logic [7:0]  c_old;
    logic [15:0] nb;
    @(negedge clk);
    evt = e; cwr = cw; cwd = cd; we = w; bwr = bw; bwd = bd; st = s;
    c_old = exp_code(m_flags);
    nb = m_bkp;
    if (w) begin
      if (bw) nb = bd;
      if (s && c_old != 0) nb[7:0] = c_old;
    end
    m_bkp = nb;
    if (cw && cd[24]) m_flags = '0;
    m_flags = m_flags | {e[3], e[2], e[1], 1'b0, e[0]};
    if ((e[2] | e[3]) && m_cnt < (1 << CW) - 1) m_cnt++;
    @(negedge clk); idle();
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    rst = 1; idle();
    m_flags = 5'b00010; m_bkp = '0; m_cnt = 0;
    void'($urandom(32'd4711));
    // R1 reset state
    do_por("R1 reset");
    // R7 store with only power-on set gives code 5; first remove flags, then store zero code
    op(4'b0000, 1, 32'h0100_0000, 0, 0, 16'h0, 0, "R4 remove");
    op(4'b0000, 0, 32'h0, 1, 0, 16'h0, 1, "R7 store zero code");
    // R2/R5 single events from a cleared state
    op(4'b0001, 0, 0, 0, 0, 0, 0, "R2 R5 pin");
    op(4'b0010, 0, 0, 0, 0, 0, 0, "R2 R5 software over pin");
    op(4'b1000, 0, 0, 0, 0, 0, 0, "R2 R5 window watchdog");
    op(4'b0100, 0, 0, 0, 0, 0, 0, "R2 R5 R11 independent watchdog");
    // R4 CSR write with bit 24 clear and other bits set changes nothing
    op(4'b0000, 1, 32'hFEFF_FFFF, 0, 0, 0, 0, "R4 no remove");
    // R9 software write of backup, then R6 store keeps upper byte
    op(4'b0000, 0, 0, 1, 1, 16'hA5C3, 0, "R9 sw write");
    op(4'b0000, 0, 0, 1, 0, 0, 1, "R6 store code 1");
    // R8 gated writes
    op(4'b0000, 0, 0, 0, 1, 16'h1234, 1, "R8 no enable");
    // R9 sw write plus store same cycle
    op(4'b0000, 0, 0, 1, 1, 16'h7E00, 1, "R9 merge");
    // R4 remove with simultaneous event, R10 backup survives
    op(4'b0001, 1, 32'h0100_0000, 0, 0, 0, 0, "R4 R10 remove plus pin");
    // R11 saturation and alarm, remove not clearing count
    for (int i = 0; i < 8; i++) op(4'b1100, 0, 0, 0, 0, 0, 0, "R11 saturate");
    op(4'b0000, 1, 32'h0100_0000, 0, 0, 0, 0, "R11 remove keeps count");
    // R3 bit 24 reads as zero after any writes
    chk("R3 remove bit reads 0", {31'b0, rdata[24]}, 32'h0);
    // R1 R10 power-on in mid run clears backup
    do_por("R1 R10 power-on again");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] e;
      logic [31:0] cd;
      e  = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0;
      cd = $urandom;
      cd[24] = ($urandom % 2 == 1);
      op(e, ($urandom % 5 == 0), cd, ($urandom % 10 < 7), ($urandom % 5 == 0),
         16'($urandom), ($urandom % 3 == 0), "R2 R4 R5 R6 R9 random");
      if (i == 300) do_por("R1 random power-on");
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog timeout actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule